// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when the whole contents of a volatile memory array are copied into its nonvolatile shadow (a store) and when the shadow is copied back (a recall). Every transfer moves all cells in one parallel operation. A modelled copy engine stands in for the arrays. It reports completion with a one-cycle done pulse after a programmable number of cycles. Port reads and writes are held off by an inhibit output for as long as a transfer runs.

A store can be requested in three ways: a supply-good input that drops low, an active-low request on a shared busy line, or a software strobe. The block keeps a dirty flag that any completed write sets. The supply-fail and busy-line requests skip the store when that flag is clear. The software request always stores. The shared line is modelled as open drain. The block can pull it low, drive it strongly high for a short hold after a requested store, or leave it to a weak pull-up. Once after reset the block runs a recall, and it keeps the port blocked until that recall ends.

Top module: `nv_xfer_seq`

## Requirements
- R1: After reset, inhibit_o is 1 and one recall runs. recall_done_o pulses once, after which inhibit_o returns to 0 and dirty_o is 0.
- R2: A write whose wr_start_i is sampled while inhibit_o is 0, followed by wr_end_i, sets dirty_o in the cycle after wr_end_i.
- R3: The completion of any store or recall clears dirty_o. inhibit_o stays 1 for the whole transfer, and the copy step lasts COPY_CYCLES+1 cycles.
- R4: When pwr_ok_i is 0 and dirty_o is 1, a store runs with busy_drv_lo_o held at 1 for the COPY_CYCLES+1 cycles of the copy. No strong-high hold follows (busy_drv_hi_o stays 0).
- R5: When pwr_ok_i is 0 and dirty_o is 0, no store runs and the line is not pulled low, however long the supply stays low.
- R6: A one-cycle sw_store_i while idle runs a store even when dirty_o is 0.
- R7: When the busy line is seen low while idle and dirty_o is 1, the block pulls the line low and waits T_DELAY cycles before starting the copy. busy_drv_lo_o is therefore 1 for T_DELAY+COPY_CYCLES+1 cycles.
- R8: After a software or busy-line store, busy_drv_hi_o is 1 for exactly T_HHHD cycles. The line is then released, with busy_pu_en_o at 1 and both drive outputs at 0.
- R9: When the busy line is seen low while idle and dirty_o is 0, busy_drv_lo_o stays 0. inhibit_o is 1 until the line is seen high again.
- R10: A write whose wr_start_i is sampled while inhibit_o is 1 is dropped. Its wr_end_i leaves dirty_o at 0.
- R11: Priority in the idle state runs from a supply-fail store with the dirty flag set, through a busy-line request, to the software strobe. A supply-fail store taken on the same cycle as sw_store_i therefore gets no strong-high hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_i | input | 1 | Supply above the switch threshold (0 = supply failing) |
| busy_line_i | input | 1 | Sensed level of the shared open-drain busy line (0 = low) |
| sw_store_i | input | 1 | Software store strobe, one cycle |
| wr_start_i | input | 1 | A port write begins this cycle |
| wr_end_i | input | 1 | The port write in progress completes this cycle |
| inhibit_o | output | 1 | Blocks new port reads and writes |
| busy_drv_lo_o | output | 1 | Pull the busy line low |
| busy_drv_hi_o | output | 1 | Drive the busy line strongly high |
| busy_pu_en_o | output | 1 | Leave the busy line to the weak pull-up |
| dirty_o | output | 1 | A write has completed since the last transfer |
| store_done_o | output | 1 | One-cycle pulse when a store completes |
| recall_done_o | output | 1 | One-cycle pulse when a recall completes |

## Verification
The main same-cycle clash is a supply failure arriving in the same cycle as a software strobe. Both want a store, but they differ in whether a strong-high hold follows it. The bench drops pwr_ok_i and pulses sw_store_i on the same edge while the dirty flag is set. It then counts one store, counts the low-drive cycles and expects zero strong-high cycles, which shows that the supply-fail path took the store. A second clash, a busy-line request seen while the dirty flag is clear, checks that the line is never pulled low and that writes attempted while the port is held are dropped.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;
  typedef enum logic [2:0] {
    S_BOOT    = 3'd0,
    S_RECALL  = 3'd1,
    S_IDLE    = 3'd2,
    S_HWWAIT  = 3'd3,
    S_STORE   = 3'd4,
    S_HOLD    = 3'd5,
    S_EXTHOLD = 3'd6
  } xfer_state_e;
endpackage

// File: rtl/nv_copy_engine.sv
module nv_copy_engine #(
  parameter int COPY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(COPY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(COPY_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/nv_dirty_track.sv
module nv_dirty_track (
  input  logic clk,
  input  logic rst,
  input  logic wr_start_i,
  input  logic wr_end_i,
  input  logic inhibit_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic inflight_q, dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight_q <= 1'b0;
      dirty_q    <= 1'b0;
    end else begin
      if (wr_start_i && !inhibit_i)
        inflight_q <= 1'b1;
      else if (wr_end_i)
        inflight_q <= 1'b0;
      if (clr_i)
        dirty_q <= 1'b0;
      else if (wr_end_i && inflight_q)
        dirty_q <= 1'b1;
    end
  end

  assign dirty_o = dirty_q;

  // R3: end of a transfer wins over a completing write
  p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !dirty_q);
  // R10: a write presented while inhibited is not tracked
  p_blocked_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_start_i && inhibit_i && !inflight_q) |=> !inflight_q);
endmodule

// File: rtl/nv_xfer_fsm.sv
module nv_xfer_fsm
  import nv_xfer_pkg::*;
#(
  parameter int T_DELAY = 4,
  parameter int T_HHHD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok_i,
  input  logic busy_line_i,
  input  logic sw_store_i,
  input  logic dirty_i,
  input  logic copy_done_i,
  output logic copy_start_o,
  output logic dirty_clr_o,
  output logic inhibit_o,
  output logic drv_lo_o,
  output logic drv_hi_o,
  output logic pu_en_o,
  output logic store_done_o,
  output logic recall_done_o
);
  localparam int TMAX = (T_DELAY > T_HHHD) ? T_DELAY : T_HHHD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] DLY_LAST  = TW'(T_DELAY - 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(T_HHHD - 1);

  xfer_state_e   state_q, state_d;
  logic          hold_q, hold_d;
  logic [TW-1:0] tmr_q;
  logic          inhibit_q, drv_lo_q, drv_hi_q, pu_en_q;
  logic          store_done_q, recall_done_q;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    unique case (state_q)
      S_BOOT:   state_d = S_RECALL;
      S_RECALL: if (copy_done_i) state_d = S_IDLE;
      S_IDLE: begin
        if (!pwr_ok_i && dirty_i) begin
          state_d = S_STORE;
          hold_d  = 1'b0;
        end else if (!busy_line_i) begin
          state_d = dirty_i ? S_HWWAIT : S_EXTHOLD;
        end else if (sw_store_i) begin
          state_d = S_STORE;
          hold_d  = 1'b1;
        end
      end
      S_HWWAIT: if (tmr_q == DLY_LAST) begin
        state_d = S_STORE;
        hold_d  = 1'b1;
      end
      S_STORE:   if (copy_done_i) state_d = hold_q ? S_HOLD : S_IDLE;
      S_HOLD:    if (tmr_q == HOLD_LAST) state_d = S_IDLE;
      S_EXTHOLD: if (busy_line_i) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  assign copy_start_o = (state_d != state_q) &&
                        (state_d == S_STORE || state_d == S_RECALL);
  assign dirty_clr_o  = copy_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_BOOT;
      hold_q        <= 1'b0;
      tmr_q         <= '0;
      inhibit_q     <= 1'b1;
      drv_lo_q      <= 1'b0;
      drv_hi_q      <= 1'b0;
      pu_en_q       <= 1'b1;
      store_done_q  <= 1'b0;
      recall_done_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      hold_q        <= hold_d;
      tmr_q         <= (state_d != state_q) ? '0 : tmr_q + 1'b1;
      inhibit_q     <= (state_d != S_IDLE);
      drv_lo_q      <= (state_d == S_HWWAIT) || (state_d == S_STORE);
      drv_hi_q      <= (state_d == S_HOLD);
      pu_en_q       <= !((state_d == S_HWWAIT) || (state_d == S_STORE) ||
                         (state_d == S_HOLD));
      store_done_q  <= copy_done_i && (state_q == S_STORE);
      recall_done_q <= copy_done_i && (state_q == S_RECALL);
    end
  end

  assign inhibit_o     = inhibit_q;
  assign drv_lo_o      = drv_lo_q;
  assign drv_hi_o      = drv_hi_q;
  assign pu_en_o       = pu_en_q;
  assign store_done_o  = store_done_q;
  assign recall_done_o = recall_done_q;

  // R8: the line is never driven both ways at once
  p_drive_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(drv_lo_q && drv_hi_q));
  // R9: a clean request never pulls the line low
  p_clean_no_pull_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && !busy_line_i && !dirty_i) |=> !drv_lo_q);
  // R4: a supply-fail store ends without a strong-high hold
  p_pf_no_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_STORE && copy_done_i && !hold_q) |=> !drv_hi_q);
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq #(
  parameter int COPY_CYCLES = 6,
  parameter int T_DELAY     = 4,
  parameter int T_HHHD      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok_i,
  input  logic busy_line_i,
  input  logic sw_store_i,
  input  logic wr_start_i,
  input  logic wr_end_i,
  output logic inhibit_o,
  output logic busy_drv_lo_o,
  output logic busy_drv_hi_o,
  output logic busy_pu_en_o,
  output logic dirty_o,
  output logic store_done_o,
  output logic recall_done_o
);
  logic copy_start, copy_busy, copy_done, dirty_clr;

  nv_copy_engine #(.COPY_CYCLES(COPY_CYCLES)) u_copy (
    .clk(clk), .rst(rst), .start_i(copy_start),
    .busy_o(copy_busy), .done_o(copy_done)
  );

  nv_dirty_track u_dirty (
    .clk(clk), .rst(rst), .wr_start_i(wr_start_i), .wr_end_i(wr_end_i),
    .inhibit_i(inhibit_o), .clr_i(dirty_clr), .dirty_o(dirty_o)
  );

  nv_xfer_fsm #(.T_DELAY(T_DELAY), .T_HHHD(T_HHHD)) u_fsm (
    .clk(clk), .rst(rst), .pwr_ok_i(pwr_ok_i), .busy_line_i(busy_line_i),
    .sw_store_i(sw_store_i), .dirty_i(dirty_o), .copy_done_i(copy_done),
    .copy_start_o(copy_start), .dirty_clr_o(dirty_clr),
    .inhibit_o(inhibit_o), .drv_lo_o(busy_drv_lo_o),
    .drv_hi_o(busy_drv_hi_o), .pu_en_o(busy_pu_en_o),
    .store_done_o(store_done_o), .recall_done_o(recall_done_o)
  );

  // R3: the port is blocked whenever the copy engine runs
  p_inhibit_in_copy_r3: assert property (@(posedge clk) disable iff (rst)
    copy_busy |-> inhibit_o);
endmodule

// File: tb/tb_nv_xfer_seq.sv
module tb_nv_xfer_seq;
  localparam int COPY_CYCLES = 6;
  localparam int T_DELAY     = 4;
  localparam int T_HHHD      = 3;
  localparam int CPY = COPY_CYCLES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b1, sw_store = 1'b0, wr_start = 1'b0, wr_end = 1'b0;
  logic ext_lo = 1'b0;
  logic busy_line;
  logic inhibit, drv_lo, drv_hi, pu_en, dirty, store_done, recall_done;

  always #4 clk = ~clk;

  assign busy_line = drv_lo ? 1'b0 : (drv_hi ? 1'b1 : !ext_lo);

  nv_xfer_seq #(.COPY_CYCLES(COPY_CYCLES), .T_DELAY(T_DELAY), .T_HHHD(T_HHHD)) dut (
    .clk(clk), .rst(rst), .pwr_ok_i(pwr_ok), .busy_line_i(busy_line),
    .sw_store_i(sw_store), .wr_start_i(wr_start), .wr_end_i(wr_end),
    .inhibit_o(inhibit), .busy_drv_lo_o(drv_lo), .busy_drv_hi_o(drv_hi),
    .busy_pu_en_o(pu_en), .dirty_o(dirty), .store_done_o(store_done),
    .recall_done_o(recall_done)
  );

  int errors = 0, checks = 0;
  int n_lo = 0, n_hi = 0, n_store = 0, n_recall = 0, n_inh = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (drv_lo) n_lo <= n_lo + 1;
    if (drv_hi) n_hi <= n_hi + 1;
    if (store_done) n_store <= n_store + 1;
    if (recall_done) n_recall <= n_recall + 1;
    if (inhibit) n_inh <= n_inh + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_mon();
    @(negedge clk);
    n_lo = 0; n_hi = 0; n_store = 0; n_recall = 0; n_inh = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && inhibit; i++) @(negedge clk);
  endtask

  task automatic do_write();
    wr_start = 1'b1; @(negedge clk);
    wr_start = 1'b0; cyc_n(2);
    wr_end = 1'b1; @(negedge clk);
    wr_end = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 inhibit in reset", int'(inhibit), 1);
    clr_mon();
    rst = 1'b0;
    cyc_n(3);
    chk("R1 inhibit during recall", int'(inhibit), 1);
    wait_idle();
    cyc_n(1);
    chk("R1 recall pulses", n_recall, 1);
    chk("R1 inhibit after recall", int'(inhibit), 0);
    chk("R1 dirty after recall", int'(dirty), 0);
    chk("R1 no drive low on recall", n_lo, 0);
  endtask

  task automatic t_write_dirty();
    do_write();
    chk("R2 dirty after write", int'(dirty), 1);
  endtask

  task automatic t_sw_clean();
    clr_mon();
    chk("R6 starts clean", int'(dirty), 0);
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
    cyc_n(2);
    chk("R3 inhibit during sw store", int'(inhibit), 1);
    wait_idle();
    cyc_n(1);
    chk("R6 sw store ran", n_store, 1);
    chk("R3 copy length sw", n_lo, CPY);
    chk("R8 hold high sw", n_hi, T_HHHD);
    chk("R8 pullup after sw", int'(pu_en), 1);
  endtask

  task automatic t_pf_store();
    do_write();
    clr_mon();
    pwr_ok = 1'b0;
    cyc_n(3);
    chk("R3 inhibit during pf store", int'(inhibit), 1);
    wait_idle();
    cyc_n(15);
    chk("R4 pf store ran once", n_store, 1);
    chk("R4 low for copy", n_lo, CPY);
    chk("R4 no hold high", n_hi, 0);
    chk("R3 dirty cleared by pf store", int'(dirty), 0);
    pwr_ok = 1'b1;
    cyc_n(1);
  endtask

  task automatic t_pf_clean();
    clr_mon();
    pwr_ok = 1'b0;
    cyc_n(20);
    chk("R5 no store when clean", n_store, 0);
    chk("R5 no pull when clean", n_lo, 0);
    pwr_ok = 1'b1;
    cyc_n(1);
  endtask

  task automatic t_hw_dirty();
    do_write();
    chk("R2 dirty before hw", int'(dirty), 1);
    clr_mon();
    ext_lo = 1'b1;
    for (int i = 0; i < 200 && n_store == 0; i++) @(negedge clk);
    ext_lo = 1'b0;
    wait_idle();
    cyc_n(1);
    chk("R7 hw store ran", n_store, 1);
    chk("R7 low for delay plus copy", n_lo, T_DELAY + CPY);
    chk("R8 hold high hw", n_hi, T_HHHD);
    chk("R8 released to pullup", int'(pu_en), 1);
    chk("R3 dirty cleared by hw store", int'(dirty), 0);
  endtask

  task automatic t_hw_clean();
    clr_mon();
    ext_lo = 1'b1;
    cyc_n(3);
    chk("R9 inhibit while held clean", int'(inhibit), 1);
    do_write();
    cyc_n(2);
    chk("R9 no drive low clean", n_lo, 0);
    chk("R9 still inhibited", int'(inhibit), 1);
    ext_lo = 1'b0;
    cyc_n(3);
    chk("R9 released after line high", int'(inhibit), 0);
    chk("R10 blocked write not dirty", int'(dirty), 0);
    chk("R9 no store when clean", n_store, 0);
  endtask

  task automatic t_collision();
    do_write();
    clr_mon();
    pwr_ok = 1'b0;
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
    wait_idle();
    cyc_n(8);
    chk("R11 one store", n_store, 1);
    chk("R11 pf path low cycles", n_lo, CPY);
    chk("R11 pf wins no hold", n_hi, 0);
    pwr_ok = 1'b1;
    cyc_n(2);
  endtask

  initial begin
    t_reset();
    t_write_dirty();
    t_pf_store();
    t_sw_clean();
    t_pf_clean();
    t_hw_dirty();
    t_hw_clean();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule